// File: doc/BRIEF.md
# Single DMA Channel with Page Register

This block is one channel of a classic byte-wide DMA engine. A host programs it through an 8-bit register port. Three select bits choose the register. A shared byte pointer lets the 16-bit address and the 16-bit count each be loaded and read back through a single 8-bit port. A separate page register supplies the top four bits of a 20-bit memory address. The channel moves bytes between an I/O device and memory. The device raises a request, and the channel answers with a one-cycle acknowledge plus a memory read or write strobe. After each byte the address steps up and the count steps down.

The count holds the number of bytes minus one. When the byte sent at count zero completes, the channel pulses terminal count and masks itself. The 16-bit address wraps inside its 64 KiB page, so the page bits never change during a transfer.

The sequencer has four states. MASKED is idle with no transfers. ARMED waits for a request. ACK is the cycle that moves one byte. RECOVER is one idle cycle between bytes. The transitions are:

- arm: MASKED to ARMED, on a matching unmask write.
- grant: ARMED to ACK, on a request.
- drain: ACK to RECOVER, while count is not zero.
- finish: ACK to MASKED, when count is zero or a mask write arrives.
- rearm: RECOVER to ARMED.
- halt: ARMED or RECOVER to MASKED, on a matching mask write.

Top module: `dma_page_channel`

## Requirements
- R1: After reset the channel is masked. The address, count, page and byte pointer are zero. dev_ack, mem_rd, mem_wr and tc are low.
- R2: The port codes on host_sel are: 0 address, 1 count, 2 page, 3 mode, 4 pointer clear, 5 mask. A 16-bit address or count is loaded by two writes to its port, low byte and then high byte. The byte pointer toggles after each accepted write.
- R3: Any write to port 4 returns the byte pointer to the low byte, whatever the data.
- R4: Reading port 0 or port 1 with host_rd shows the current value on host_rdata combinationally, low byte and then high byte, and toggles the same pointer. Port 2 reads as the page value zero-extended to 8 bits.
- R5: mem_addr equals {page, address}. A page write keeps only data bits [3:0].
- R6: In a mode write, bits [1:0] must equal the channel number 3, or the write is ignored. Bits [3:2] select the transfer kind: 01 is device-to-memory and pulses mem_wr, 10 is memory-to-device and pulses mem_rd, 00 and 11 are verify and pulse neither strobe. So 0x47 selects device-to-memory and 0x4B selects memory-to-device.
- R7: In a mask write, bits [1:0] must equal 3, or the write is ignored. Bit 2 = 1 masks the channel and bit 2 = 0 unmasks it, so writing 3 unmasks.
- R8: If the channel is ARMED and dev_req is high at a clock edge, the next cycle carries dev_ack for exactly one cycle, together with the selected strobe. One idle cycle always separates two acknowledges.
- R9: A count of N moves N+1 bytes. tc is high only in the acknowledge cycle of the byte sent at count zero. The count then reads 0xFFFF and the channel is masked.
- R10: The address steps up by one per byte and wraps from 0xFFFF to 0x0000. The page does not change.
- R11: While the channel is unmasked, writes to the address, count, page and mode ports are ignored and do not toggle the pointer.
- R12: A mask write that arrives in the same cycle as a request in ARMED wins, and no acknowledge follows. A host read during an acknowledge cycle returns the value from before that byte's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_sel | input | 3 | Register port code |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (combinational) |
| dev_req | input | 1 | Device transfer request |
| dev_ack | output | 1 | Device acknowledge, one cycle per byte |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 20 | Memory address {page, address} |
| tc | output | 1 | Terminal count pulse |

## Verification
Two pairs of functions can meet in a single cycle. The first is a host mask write and a device request while the channel is ARMED. The bench drives both on the same falling edge, then holds the request for several more cycles and expects no acknowledge and an unchanged count. The second is a host read of the count during an acknowledge cycle. The bench waits until it sees dev_ack, raises host_rd in that same cycle, and expects the count from before the decrement. The bench then reads the pointer again to confirm that this read toggled it.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    localparam int HOST_W = 8;
    localparam int REG_W  = 16;
    localparam int SEL_W  = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_ADDR   = 3'd0,
        SEL_COUNT  = 3'd1,
        SEL_PAGE   = 3'd2,
        SEL_MODE   = 3'd3,
        SEL_PTRCLR = 3'd4,
        SEL_MASK   = 3'd5
    } port_sel_e;

    typedef enum logic [1:0] {
        XK_VERIFY   = 2'b00,
        XK_TO_MEM   = 2'b01,
        XK_FROM_MEM = 2'b10,
        XK_RSVD     = 2'b11
    } xfer_kind_e;

    typedef enum logic [1:0] {
        ST_MASKED,
        ST_ARMED,
        ST_ACK,
        ST_RECOVER
    } chan_state_e;

endpackage

// File: rtl/dma_pair_reg.sv
module dma_pair_reg #(
    parameter int WIDTH      = 16,
    parameter bit COUNT_DOWN = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic               hi_i,
    input  logic [WIDTH/2-1:0] data_i,
    input  logic               step_i,
    output logic [WIDTH-1:0]   value_o
);

    localparam int HALF = WIDTH / 2;
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    logic [WIDTH-1:0] value_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value_q <= '0;
        end else if (load_i) begin
            if (hi_i) value_q[WIDTH-1:HALF] <= data_i;
            else      value_q[HALF-1:0]     <= data_i;
        end else if (step_i) begin
            if (COUNT_DOWN) value_q <= value_q - ONE;
            else            value_q <= value_q + ONE;
        end
    end

    assign value_o = value_q;

    generate
        if (COUNT_DOWN) begin : g_down
            // Count drops by exactly one per byte moved
            assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (step_i && !load_i) |=> (value_q == $past(value_q) - ONE));
        end else begin : g_up
            // Address rises by one per byte, wrapping modulo 2^WIDTH
            assert_addr_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
                (step_i && !load_i) |=> (value_q == $past(value_q) + ONE));
        end
    endgenerate

endmodule

// File: rtl/dma_host_regs.sv
module dma_host_regs
    import dma_chan_pkg::*;
#(
    parameter int PAGE_W  = 4,
    parameter int CHAN_W  = 2,
    parameter int CHAN_ID = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [SEL_W-1:0]  host_sel,
    input  logic [HOST_W-1:0] host_wdata,
    output logic [HOST_W-1:0] host_rdata,
    input  logic              masked_i,
    input  logic              step_i,
    output logic [REG_W-1:0]  addr_o,
    output logic [REG_W-1:0]  cnt_o,
    output logic [PAGE_W-1:0] page_o,
    output xfer_kind_e        kind_o,
    output logic              mask_set_o,
    output logic              mask_clr_o
);

    localparam int KIND_LSB = CHAN_W;
    localparam logic [CHAN_W-1:0] CHAN_CODE = CHAN_W'(CHAN_ID);

    logic        ptr_q;
    logic [PAGE_W-1:0] page_q;
    xfer_kind_e  kind_q;
    logic        chan_match;
    logic        wr_addr, wr_cnt, wr_page, wr_mode, wr_ptrclr, rd_pair;

    assign chan_match = (host_wdata[CHAN_W-1:0] == CHAN_CODE);
    assign wr_addr    = host_wr && masked_i && (host_sel == SEL_ADDR);
    assign wr_cnt     = host_wr && masked_i && (host_sel == SEL_COUNT);
    assign wr_page    = host_wr && masked_i && (host_sel == SEL_PAGE);
    assign wr_mode    = host_wr && masked_i && (host_sel == SEL_MODE) && chan_match;
    assign wr_ptrclr  = host_wr && (host_sel == SEL_PTRCLR);
    assign rd_pair    = host_rd && !host_wr &&
                        ((host_sel == SEL_ADDR) || (host_sel == SEL_COUNT));
    assign mask_set_o = host_wr && (host_sel == SEL_MASK) && chan_match &&  host_wdata[CHAN_W];
    assign mask_clr_o = host_wr && (host_sel == SEL_MASK) && chan_match && !host_wdata[CHAN_W];

    // Shared byte pointer
    always_ff @(posedge clk) begin
        if (!rst_n)                 ptr_q <= 1'b0;
        else if (wr_ptrclr)         ptr_q <= 1'b0;
        else if (wr_addr || wr_cnt) ptr_q <= ~ptr_q;
        else if (rd_pair)           ptr_q <= ~ptr_q;
    end

    dma_pair_reg #(.WIDTH(REG_W), .COUNT_DOWN(1'b0)) u_addr (
        .clk(clk), .rst_n(rst_n), .load_i(wr_addr), .hi_i(ptr_q),
        .data_i(host_wdata), .step_i(step_i), .value_o(addr_o)
    );

    dma_pair_reg #(.WIDTH(REG_W), .COUNT_DOWN(1'b1)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load_i(wr_cnt), .hi_i(ptr_q),
        .data_i(host_wdata), .step_i(step_i), .value_o(cnt_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
            kind_q <= XK_VERIFY;
        end else begin
            if (wr_page) page_q <= host_wdata[PAGE_W-1:0];
            if (wr_mode) kind_q <= xfer_kind_e'(host_wdata[KIND_LSB +: 2]);
        end
    end

    assign page_o = page_q;
    assign kind_o = kind_q;

    always_comb begin
        host_rdata = '0;
        unique case (host_sel)
            SEL_ADDR:  host_rdata = ptr_q ? addr_o[REG_W-1:HOST_W] : addr_o[HOST_W-1:0];
            SEL_COUNT: host_rdata = ptr_q ? cnt_o[REG_W-1:HOST_W]  : cnt_o[HOST_W-1:0];
            SEL_PAGE:  host_rdata = HOST_W'(page_q);
            default:   host_rdata = '0;
        endcase
    end

    // Page and mode are frozen while the channel runs
    assert_page_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !masked_i |=> $stable(page_q));
    assert_mode_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !masked_i |=> $stable(kind_q));
    // A pointer-clear write always lands on the low byte
    assert_ptr_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ptrclr |=> !ptr_q);

endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
    import dma_chan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       unmask_i,
    input  logic       mask_i,
    input  logic       dev_req_i,
    input  logic       cnt_zero_i,
    input  xfer_kind_e kind_i,
    output logic       masked_o,
    output logic       step_o,
    output logic       dev_ack_o,
    output logic       mem_rd_o,
    output logic       mem_wr_o,
    output logic       tc_o
);

    chan_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_MASKED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_MASKED:  if (unmask_i && !mask_i) state_d = ST_ARMED;
            ST_ARMED:   if (mask_i)              state_d = ST_MASKED;
                        else if (dev_req_i)      state_d = ST_ACK;
            ST_ACK:     if (cnt_zero_i || mask_i) state_d = ST_MASKED;
                        else                      state_d = ST_RECOVER;
            ST_RECOVER: if (mask_i)              state_d = ST_MASKED;
                        else                      state_d = ST_ARMED;
            default:    state_d = ST_MASKED;
        endcase
    end

    always_comb begin
        masked_o  = 1'b0;
        step_o    = 1'b0;
        dev_ack_o = 1'b0;
        mem_rd_o  = 1'b0;
        mem_wr_o  = 1'b0;
        tc_o      = 1'b0;
        unique case (state_q)
            ST_MASKED: masked_o = 1'b1;
            ST_ACK: begin
                step_o    = 1'b1;
                dev_ack_o = 1'b1;
                mem_wr_o  = (kind_i == XK_TO_MEM);
                mem_rd_o  = (kind_i == XK_FROM_MEM);
                tc_o      = cnt_zero_i;
            end
            default: ;
        endcase
    end

    assert_ack_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dev_ack_o |=> !dev_ack_o);
    assert_ack_after_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dev_ack_o |-> $past(dev_req_i));
    assert_tc_masks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tc_o |=> (masked_o && !dev_ack_o));
    assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd_o, mem_wr_o}));
    assert_mask_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && mask_i) |=> !dev_ack_o);

endmodule

// File: rtl/dma_page_channel.sv
module dma_page_channel
    import dma_chan_pkg::*;
#(
    parameter int PAGE_W  = 4,
    parameter int CHAN_W  = 2,
    parameter int CHAN_ID = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    host_wr,
    input  logic                    host_rd,
    input  logic [SEL_W-1:0]        host_sel,
    input  logic [HOST_W-1:0]       host_wdata,
    output logic [HOST_W-1:0]       host_rdata,
    input  logic                    dev_req,
    output logic                    dev_ack,
    output logic                    mem_rd,
    output logic                    mem_wr,
    output logic [REG_W+PAGE_W-1:0] mem_addr,
    output logic                    tc
);

    logic [REG_W-1:0]  addr_w, cnt_w;
    logic [PAGE_W-1:0] page_w;
    xfer_kind_e        kind_w;
    logic              masked_w, step_w, mask_set_w, mask_clr_w;

    dma_host_regs #(.PAGE_W(PAGE_W), .CHAN_W(CHAN_W), .CHAN_ID(CHAN_ID)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_rd(host_rd), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .masked_i(masked_w), .step_i(step_w),
        .addr_o(addr_w), .cnt_o(cnt_w), .page_o(page_w), .kind_o(kind_w),
        .mask_set_o(mask_set_w), .mask_clr_o(mask_clr_w)
    );

    dma_seq_fsm u_seq (
        .clk(clk), .rst_n(rst_n),
        .unmask_i(mask_clr_w), .mask_i(mask_set_w),
        .dev_req_i(dev_req), .cnt_zero_i(cnt_w == '0), .kind_i(kind_w),
        .masked_o(masked_w), .step_o(step_w), .dev_ack_o(dev_ack),
        .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .tc_o(tc)
    );

    assign mem_addr = {page_w, addr_w};

    // Page bits never move between two bytes of one run
    assert_page_fixed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dev_ack |=> (mem_addr[REG_W+PAGE_W-1:REG_W] == $past(mem_addr[REG_W+PAGE_W-1:REG_W])));

endmodule

// File: tb/dma_page_channel_tb.sv
module dma_page_channel_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [2:0]  host_sel = 3'd0;
    logic [7:0]  host_wdata = 8'd0;
    logic [7:0]  host_rdata;
    logic        dev_req = 1'b0;
    logic        dev_ack, mem_rd, mem_wr, tc;
    logic [19:0] mem_addr;

    int checks = 0, errors = 0;
    int mon_checks = 0, mon_errors = 0;
    int ack_seen = 0;
    logic [22:0] exp_q[$];

    localparam logic [2:0] P_ADDR = 3'd0, P_CNT = 3'd1, P_PAGE = 3'd2,
                           P_MODE = 3'd3, P_CLR = 3'd4, P_MASK = 3'd5;

    always #5 clk = ~clk;

    dma_page_channel dut_i (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .dev_req(dev_req), .dev_ack(dev_ack), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .tc(tc)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_sel = sel; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] sel, output logic [7:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_sel = sel;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic load16(input logic [2:0] sel, input logic [15:0] v);
        wr(P_CLR, 8'h5A);
        wr(sel, v[7:0]);
        wr(sel, v[15:8]);
    endtask

    task automatic read16(input logic [2:0] sel, output logic [15:0] v);
        logic [7:0] lo, hi;
        wr(P_CLR, 8'h00);
        rd(sel, lo);
        rd(sel, hi);
        v = {hi, lo};
    endtask

    // Scoreboard item: {tc, mem_rd, mem_wr, mem_addr}
    task automatic expect_byte(input logic [19:0] a, input logic r, input logic w, input logic t);
        exp_q.push_back({t, r, w, a});
    endtask

    task automatic run_bytes();
        dev_req = 1'b1;
        for (int i = 0; i < 400 && exp_q.size() != 0; i++) @(negedge clk);
        repeat (12) @(negedge clk);
        dev_req = 1'b0;
        check("R9 all expected bytes moved", exp_q.size(), 0);
    endtask

    // Monitor: pops scoreboard on every acknowledge
    always @(negedge clk) begin
        if (rst_n && dev_ack) begin
            ack_seen++;
            mon_checks++;
            if (exp_q.size() == 0) begin
                mon_errors++;
                $display("FAIL R9/R11 unexpected ack actual=%h expected=none", {tc, mem_rd, mem_wr, mem_addr});
            end else begin
                logic [22:0] e;
                e = exp_q.pop_front();
                if ({tc, mem_rd, mem_wr, mem_addr} !== e) begin
                    mon_errors++;
                    $display("FAIL R5/R6/R8/R10 byte actual=%h expected=%h",
                             {tc, mem_rd, mem_wr, mem_addr}, e);
                end
            end
        end else if (rst_n && (mem_rd || mem_wr || tc)) begin
            mon_errors++;
            $display("FAIL R8 strobe without ack actual=%b expected=000", {mem_rd, mem_wr, tc});
        end
    end

    task automatic finish_run(input int extra);
        $display("CHECKS %0d ERRORS %0d", checks + mon_checks, errors + mon_errors + extra);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run(1);
    end

    initial begin
        logic [15:0] v;
        logic [7:0]  b;
        int          base;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 dev_ack", dev_ack, 0);
        check("R1 strobes and tc", {mem_rd, mem_wr, tc}, 0);
        check("R1 mem_addr", mem_addr, 0);
        read16(P_ADDR, v); check("R1 address", v, 0);
        read16(P_CNT, v);  check("R1 count", v, 0);

        // R2 R4 R5 programming and readback
        wr(P_MODE, 8'h47);
        load16(P_ADDR, 16'hFFFE);
        wr(P_PAGE, 8'h15);
        load16(P_CNT, 16'h0003);
        read16(P_ADDR, v); check("R2 R4 address readback", v, 16'hFFFE);
        read16(P_CNT, v);  check("R2 R4 count readback", v, 16'h0003);
        rd(P_PAGE, b);     check("R5 page keeps low nibble", b, 8'h05);
        check("R5 mem_addr concatenation", mem_addr, 20'h5FFFE);

        // R10 wrap within page, R6 device-to-memory, R9 tc on fourth byte
        expect_byte(20'h5FFFE, 0, 1, 0);
        expect_byte(20'h5FFFF, 0, 1, 0);
        expect_byte(20'h50000, 0, 1, 0);
        expect_byte(20'h50001, 0, 1, 1);
        base = ack_seen;
        wr(P_MASK, 8'h03);
        run_bytes();
        check("R9 count of four bytes", ack_seen - base, 4);
        read16(P_ADDR, v); check("R10 address wrapped", v, 16'h0002);
        read16(P_CNT, v);  check("R9 count after tc", v, 16'hFFFF);
        check("R10 page unchanged", mem_addr[19:16], 4'h5);
        base = ack_seen;
        dev_req = 1'b1; repeat (10) @(negedge clk); dev_req = 1'b0;
        check("R9 masked after tc", ack_seen - base, 0);

        // R3 pointer clear mid-load
        wr(P_CLR, 8'hFF);
        wr(P_ADDR, 8'h34);
        wr(P_CLR, 8'h00);
        wr(P_ADDR, 8'h78);
        wr(P_ADDR, 8'h12);
        read16(P_ADDR, v); check("R3 pointer clear restarts low byte", v, 16'h1278);

        // R6 memory-to-device, R8 one-cycle ack timing
        wr(P_MODE, 8'h4B);
        wr(P_PAGE, 8'h02);
        load16(P_CNT, 16'h0000);
        expect_byte(20'h21278, 1, 0, 1);
        wr(P_MASK, 8'h03);
        @(negedge clk); dev_req = 1'b1;
        @(negedge clk); check("R8 ack in cycle after request", dev_ack, 1);
        @(negedge clk); check("R8 ack lasts one cycle", dev_ack, 0);
        dev_req = 1'b0;
        check("R9 single byte for count zero", exp_q.size(), 0);

        // R6 mode write for another channel is ignored
        wr(P_MODE, 8'h44);
        load16(P_ADDR, 16'h0100);
        load16(P_CNT, 16'h0001);
        expect_byte(20'h20100, 1, 0, 0);
        expect_byte(20'h20101, 1, 0, 1);
        wr(P_MASK, 8'h03);
        run_bytes();

        // R7 unmask for another channel is ignored
        wr(P_MODE, 8'h43);
        load16(P_ADDR, 16'h0180);
        load16(P_CNT, 16'h0000);
        base = ack_seen;
        wr(P_MASK, 8'h00);
        dev_req = 1'b1; repeat (8) @(negedge clk); dev_req = 1'b0;
        check("R7 foreign unmask ignored", ack_seen - base, 0);
        // R6 verify kind: ack with no strobe
        expect_byte(20'h20180, 0, 0, 1);
        wr(P_MASK, 8'h03);
        run_bytes();

        // R11 writes ignored while unmasked
        wr(P_MODE, 8'h47);
        wr(P_PAGE, 8'h03);
        load16(P_ADDR, 16'h0200);
        load16(P_CNT, 16'h0001);
        wr(P_CLR, 8'h00);
        wr(P_MASK, 8'h03);
        wr(P_ADDR, 8'h55);
        wr(P_PAGE, 8'h09);
        wr(P_MODE, 8'h4B);
        rd(P_ADDR, b); check("R11 pointer not toggled by ignored write", b, 8'h00);
        read16(P_ADDR, v); check("R11 address write ignored", v, 16'h0200);
        check("R11 page write ignored", mem_addr[19:16], 4'h3);
        expect_byte(20'h30200, 0, 1, 0);
        expect_byte(20'h30201, 0, 1, 1);
        run_bytes();

        // R12 mask write and request in the same cycle
        load16(P_ADDR, 16'h0300);
        load16(P_CNT, 16'h0000);
        wr(P_MASK, 8'h03);
        base = ack_seen;
        @(negedge clk);
        dev_req = 1'b1; host_wr = 1'b1; host_sel = P_MASK; host_wdata = 8'h07;
        @(negedge clk);
        host_wr = 1'b0;
        repeat (8) @(negedge clk);
        dev_req = 1'b0;
        check("R12 mask wins over request", ack_seen - base, 0);
        read16(P_CNT, v); check("R12 count untouched after mask", v, 16'h0000);

        // R12 host read during an acknowledge cycle sees pre-update value
        load16(P_ADDR, 16'h0400);
        load16(P_CNT, 16'h0002);
        expect_byte(20'h30400, 0, 1, 0);
        expect_byte(20'h30401, 0, 1, 0);
        expect_byte(20'h30402, 0, 1, 1);
        wr(P_CLR, 8'h00);
        wr(P_MASK, 8'h03);
        dev_req = 1'b1;
        for (int i = 0; i < 20 && !dev_ack; i++) @(negedge clk);
        host_rd = 1'b1; host_sel = P_CNT;
        #1 check("R12 read in ack cycle returns pre-decrement", host_rdata, 8'h02);
        @(negedge clk);
        host_rd = 1'b0;
        for (int i = 0; i < 40 && exp_q.size() != 0; i++) @(negedge clk);
        repeat (4) @(negedge clk);
        dev_req = 1'b0;
        rd(P_CNT, b); check("R4 read toggled pointer to high byte", b, 8'hFF);
        check("R9 run of three done", exp_q.size(), 0);

        repeat (4) @(negedge clk);
        finish_run(0);
    end

endmodule